// File: doc/BRIEF.md
# Keypad Tone Word Controller

This block sits between a debounced keypad and a burst-tone synthesiser. The synthesiser's 8-bit control word is the phase increment of a 14-bit accumulator clocked at 5 MHz. It plays ten sine periods under a raised-cosine window, so one word step moves the tone by about 3.05 kHz. Each key arrives as a single-cycle pulse. The block keeps two words. The committed word feeds the synthesiser. The candidate word is the value the operator is editing, and it goes out for display.

An edit session opens with the edit key. Two keys then change the candidate. The coarse key jumps to the next rung of a ladder of base tones. The fine key adds one word step. The confirm key closes the session, copies the candidate into the committed word and announces this with a one-cycle strobe. The restore key returns everything to the 50 kHz default at any time.

The ladder and the default are computed at elaboration from the tone frequencies, the accumulator width, the synthesiser clock and the burst length. Retuning the block therefore changes only parameters.

Top module: `tone_word_ctrl`

## Requirements
- R1: After `rst_n` is low, and in the cycle after a `key_reset` pulse, both `word` and `cand_word` equal 16 (the 50 kHz word) and `edit_active` is 0. A `key_reset` pulse also raises `word_valid` for that cycle.
- R2: A `key_set` pulse while not editing raises `edit_active` and loads `cand_word` with the committed `word`. A `key_set` pulse while editing has no effect.
- R3: While editing, a `key_coarse` pulse moves `cand_word` to the smallest rung strictly above it. The rungs are 16, 23, 39, 56, 72, 88, 105, 121, 138 and 154, for the tones 50, 70, 120, ..., 470 kHz. From 154 or above, it moves to 164.
- R4: While editing, a `key_fine` pulse raises `cand_word` by exactly 1 when it is below 164.
- R5: While `edit_active` is 0, `key_coarse`, `key_fine` and `key_ok` leave both `cand_word` and `word` unchanged.
- R6: `cand_word` never exceeds 164, the 500 kHz word. Coarse and fine presses at 164 leave it at 164.
- R7: While editing, a `key_ok` pulse copies `cand_word` into `word`, drops `edit_active` and raises `word_valid` for exactly one cycle.
- R8: `word` changes only in a cycle where `word_valid` is 1. Candidate edits never reach `word` before confirmation.
- R9: When keys coincide in one cycle, the order of precedence is `key_reset`, then `key_ok`, then `key_set`, then `key_coarse`, then `key_fine`. Keys with lower precedence are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_set | input | 1 | Open-edit key pulse |
| key_coarse | input | 1 | Coarse (ladder) key pulse |
| key_fine | input | 1 | Fine (+1 word) key pulse |
| key_ok | input | 1 | Confirm key pulse |
| key_reset | input | 1 | Restore-default key pulse |
| cand_word | output | 8 | Candidate word for display |
| edit_active | output | 1 | High while an edit session is open |
| word | output | 8 | Committed synthesiser control word |
| word_valid | output | 1 | One-cycle strobe when `word` is written |

## Verification
Some rules can be judged from two adjacent cycles, and the assertions check these on every cycle. They cover the restore value, the opening of a session, the +1 fine step, the ceiling, the inactivity of keys outside a session, the commit and its strobe, and the rule that `word` moves only with the strobe. One property cannot see the exact ladder values: it only checks that a coarse press moves upward. The bench's reference model supplies those values by walking the whole ladder, including re-entry onto the ladder after fine steps. The bench also covers precedence among coincident keys and long random key sequences.

// File: rtl/tone_word_pkg.sv
package tone_word_pkg;

   // Resolved action for one clock, highest precedence first
   typedef enum logic [2:0] {
      ACT_NONE   = 3'd0,
      ACT_RESET  = 3'd1,
      ACT_COMMIT = 3'd2,
      ACT_OPEN   = 3'd3,
      ACT_COARSE = 3'd4,
      ACT_FINE   = 3'd5
   } tw_action_e;

   // Nearest phase increment for a burst tone given in kHz
   function automatic int tone_to_word(input int khz, input int phase_bits,
                                       input int clk_hz, input int cycles);
      longint num;
      longint den;
      num = longint'(khz) * 64'd1000 * (64'd1 << phase_bits);
      den = longint'(cycles) * longint'(clk_hz);
      return int'((num + den / 2) / den);
   endfunction

endpackage

// File: rtl/tw_decode.sv
module tw_decode
   import tone_word_pkg::*;
(
   input  logic       editing,
   input  logic       k_set,
   input  logic       k_coarse,
   input  logic       k_fine,
   input  logic       k_ok,
   input  logic       k_reset,
   output tw_action_e action
);

   always_comb begin
      action = ACT_NONE;
      if (k_reset)
         action = ACT_RESET;
      else if (editing) begin
         if (k_ok)
            action = ACT_COMMIT;
         else if (k_coarse)
            action = ACT_COARSE;
         else if (k_fine)
            action = ACT_FINE;
      end
      else if (k_set)
         action = ACT_OPEN;
   end

endmodule

// File: rtl/tw_ladder.sv
module tw_ladder
   import tone_word_pkg::*;
#(
   parameter int WORD_W     = 8,
   parameter int PHASE_BITS = 14,
   parameter int DDS_CLK_HZ = 5_000_000,
   parameter int BURST_CYC  = 10,
   parameter int BASE_KHZ   = 50,
   parameter int FIRST_KHZ  = 70,
   parameter int STEP_KHZ   = 50,
   parameter int TOP_KHZ    = 500
) (
   input  logic [WORD_W-1:0] cur,
   output logic [WORD_W-1:0] nxt
);

   localparam int RUNGS   = (TOP_KHZ - FIRST_KHZ) / STEP_KHZ + 2;
   localparam int TOP_RAW = tone_to_word(TOP_KHZ, PHASE_BITS, DDS_CLK_HZ, BURST_CYC);
   localparam logic [WORD_W-1:0] TOP_WORD = WORD_W'(TOP_RAW);

   logic [WORD_W-1:0] rung [RUNGS];

   for (genvar i = 0; i < RUNGS; i++) begin : g_rung
      localparam int KHZ = (i == 0) ? BASE_KHZ : FIRST_KHZ + (i - 1) * STEP_KHZ;
      localparam int RAW = tone_to_word(KHZ, PHASE_BITS, DDS_CLK_HZ, BURST_CYC);
      localparam int CLP = (RAW > TOP_RAW) ? TOP_RAW : RAW;
      assign rung[i] = WORD_W'(CLP);
   end

   // Descending scan: the last hit is the smallest rung above cur
   always_comb begin
      nxt = TOP_WORD;
      for (int i = RUNGS - 1; i >= 0; i--) begin
         if (rung[i] > cur)
            nxt = rung[i];
      end
   end

endmodule

// File: rtl/tw_fine.sv
module tw_fine #(
   parameter int WORD_W    = 8,
   parameter int MAX_WORD  = 164,
   parameter int FINE_STEP = 1
) (
   input  logic [WORD_W-1:0] cur,
   output logic [WORD_W-1:0] nxt
);

   localparam logic [WORD_W-1:0] CEIL = WORD_W'(MAX_WORD);
   localparam logic [WORD_W-1:0] INC  = WORD_W'(FINE_STEP);

   if (FINE_STEP == 1) begin : g_unit
      assign nxt = (cur >= CEIL) ? CEIL : cur + 1'b1;
   end
   else begin : g_multi
      // Headroom test avoids an overflowing sum
      assign nxt = (CEIL - cur <= INC || cur >= CEIL) ? CEIL : cur + INC;
   end

endmodule

// File: rtl/tone_word_ctrl.sv
module tone_word_ctrl
   import tone_word_pkg::*;
#(
   parameter int WORD_W     = 8,
   parameter int PHASE_BITS = 14,
   parameter int DDS_CLK_HZ = 5_000_000,
   parameter int BURST_CYC  = 10,
   parameter int BASE_KHZ   = 50,
   parameter int FIRST_KHZ  = 70,
   parameter int STEP_KHZ   = 50,
   parameter int TOP_KHZ    = 500,
   parameter int FINE_STEP  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_set,
   input  logic              key_coarse,
   input  logic              key_fine,
   input  logic              key_ok,
   input  logic              key_reset,
   output logic [WORD_W-1:0] cand_word,
   output logic              edit_active,
   output logic [WORD_W-1:0] word,
   output logic              word_valid
);

   localparam int DEF_WORD = tone_to_word(BASE_KHZ, PHASE_BITS, DDS_CLK_HZ, BURST_CYC);
   localparam int MAX_WORD = tone_to_word(TOP_KHZ, PHASE_BITS, DDS_CLK_HZ, BURST_CYC);
   localparam logic [WORD_W-1:0] DEF_W = WORD_W'(DEF_WORD);

   if (MAX_WORD >= (1 << WORD_W)) begin : g_chk_width
      $error("tone_word_ctrl: WORD_W too narrow for the top tone");
   end
   if (FIRST_KHZ <= BASE_KHZ || STEP_KHZ <= 0 || TOP_KHZ < FIRST_KHZ) begin : g_chk_ladder
      $error("tone_word_ctrl: ladder frequencies inconsistent");
   end
   if (FINE_STEP < 1) begin : g_chk_fine
      $error("tone_word_ctrl: FINE_STEP must be positive");
   end

   tw_action_e        act;
   logic [WORD_W-1:0] coarse_nxt;
   logic [WORD_W-1:0] fine_nxt;
   logic [WORD_W-1:0] cand_q;
   logic [WORD_W-1:0] word_q;
   logic              edit_q;
   logic              valid_q;

   tw_decode u_decode (
      .editing  (edit_q),
      .k_set    (key_set),
      .k_coarse (key_coarse),
      .k_fine   (key_fine),
      .k_ok     (key_ok),
      .k_reset  (key_reset),
      .action   (act)
   );

   tw_ladder #(
      .WORD_W     (WORD_W),
      .PHASE_BITS (PHASE_BITS),
      .DDS_CLK_HZ (DDS_CLK_HZ),
      .BURST_CYC  (BURST_CYC),
      .BASE_KHZ   (BASE_KHZ),
      .FIRST_KHZ  (FIRST_KHZ),
      .STEP_KHZ   (STEP_KHZ),
      .TOP_KHZ    (TOP_KHZ)
   ) u_ladder (
      .cur (cand_q),
      .nxt (coarse_nxt)
   );

   tw_fine #(
      .WORD_W    (WORD_W),
      .MAX_WORD  (MAX_WORD),
      .FINE_STEP (FINE_STEP)
   ) u_fine (
      .cur (cand_q),
      .nxt (fine_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand_q  <= DEF_W;
         word_q  <= DEF_W;
         edit_q  <= 1'b0;
         valid_q <= 1'b0;
      end
      else begin
         valid_q <= 1'b0;
         case (act)
            ACT_RESET: begin
               cand_q  <= DEF_W;
               word_q  <= DEF_W;
               edit_q  <= 1'b0;
               valid_q <= 1'b1;
            end
            ACT_COMMIT: begin
               word_q  <= cand_q;
               edit_q  <= 1'b0;
               valid_q <= 1'b1;
            end
            ACT_OPEN: begin
               edit_q <= 1'b1;
               cand_q <= word_q;
            end
            ACT_COARSE: cand_q <= coarse_nxt;
            ACT_FINE:   cand_q <= fine_nxt;
            default:    ;
         endcase
      end
   end

   assign cand_word   = cand_q;
   assign edit_active = edit_q;
   assign word        = word_q;
   assign word_valid  = valid_q;

endmodule

// File: rtl/tone_word_ctrl_chk.sv
module tone_word_ctrl_chk #(
   parameter int WORD_W   = 8,
   parameter int DEF_WORD = 16,
   parameter int MAX_WORD = 164
) (
   input logic              clk,
   input logic              rst_n,
   input logic              key_set,
   input logic              key_coarse,
   input logic              key_fine,
   input logic              key_ok,
   input logic              key_reset,
   input logic [WORD_W-1:0] cand_word,
   input logic              edit_active,
   input logic [WORD_W-1:0] word,
   input logic              word_valid
);

   localparam logic [WORD_W-1:0] DEF_W = WORD_W'(DEF_WORD);
   localparam logic [WORD_W-1:0] MAX_W = WORD_W'(MAX_WORD);

   p_restore_r1: assert property (@(posedge clk) disable iff (!rst_n)
      key_reset |=> (word == DEF_W && cand_word == DEF_W && !edit_active && word_valid));

   p_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!edit_active && key_set && !key_reset) |=> (edit_active && cand_word == $past(word)));

   p_coarse_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (edit_active && key_coarse && !key_ok && !key_reset)
      |=> (cand_word > $past(cand_word) || cand_word == MAX_W));

   p_fine_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (edit_active && key_fine && !key_coarse && !key_ok && !key_reset && cand_word < MAX_W)
      |=> (cand_word == $past(cand_word) + 1'b1));

   p_idle_keys_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!edit_active && !key_set && !key_reset) |=> ($stable(cand_word) && $stable(word)));

   p_ceiling_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cand_word <= MAX_W);

   p_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (edit_active && key_ok && !key_reset)
      |=> (word_valid && !edit_active && word == $past(cand_word)));

   p_word_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(word) |-> word_valid);

   p_ok_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (edit_active && key_ok && (key_coarse || key_fine) && !key_reset)
      |=> (!edit_active && $stable(cand_word)));

endmodule

bind tone_word_ctrl tone_word_ctrl_chk #(
   .WORD_W   (WORD_W),
   .DEF_WORD (DEF_WORD),
   .MAX_WORD (MAX_WORD)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .key_set     (key_set),
   .key_coarse  (key_coarse),
   .key_fine    (key_fine),
   .key_ok      (key_ok),
   .key_reset   (key_reset),
   .cand_word   (cand_word),
   .edit_active (edit_active),
   .word        (word),
   .word_valid  (word_valid)
);

// File: tb/tb_tone_word_ctrl.sv
module tb_tone_word_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       key_set = 1'b0, key_coarse = 1'b0, key_fine = 1'b0;
   logic       key_ok = 1'b0, key_reset = 1'b0;
   logic [7:0] cand_word, word;
   logic       edit_active, word_valid;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference state
   int  m_cand = 16;
   int  m_word = 16;
   bit  m_edit = 1'b0;
   bit  m_valid = 1'b0;

   always #10 clk = ~clk;

   tone_word_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .key_set(key_set), .key_coarse(key_coarse), .key_fine(key_fine),
      .key_ok(key_ok), .key_reset(key_reset),
      .cand_word(cand_word), .edit_active(edit_active),
      .word(word), .word_valid(word_valid)
   );

   // R3 ladder words for 50, 70, 120 ... 470 kHz; 164 beyond
   function automatic int ladder_next(input int c);
      int rungs [10] = '{16, 23, 39, 56, 72, 88, 105, 121, 138, 154};
      for (int i = 0; i < 10; i++)
         if (rungs[i] > c) return rungs[i];
      return 164;
   endfunction

   function automatic void model_step(input bit s, input bit c, input bit f,
                                      input bit o, input bit r);
      m_valid = 1'b0;
      if (r) begin
         m_cand = 16; m_word = 16; m_edit = 1'b0; m_valid = 1'b1;
      end
      else if (m_edit && o) begin
         m_word = m_cand; m_edit = 1'b0; m_valid = 1'b1;
      end
      else if (!m_edit && s) begin
         m_edit = 1'b1; m_cand = m_word;
      end
      else if (m_edit && c)
         m_cand = ladder_next(m_cand);
      else if (m_edit && f)
         m_cand = (m_cand >= 164) ? 164 : m_cand + 1;
   endfunction

   task automatic check(input string tag);
      checks++;
      if (int'(cand_word) != m_cand || int'(word) != m_word ||
          edit_active != m_edit || word_valid != m_valid) begin
         fails++;
         $display("FAIL %s: got cand=%0d word=%0d edit=%0b valid=%0b exp cand=%0d word=%0d edit=%0b valid=%0b",
                  tag, cand_word, word, edit_active, word_valid,
                  m_cand, m_word, m_edit, m_valid);
      end
   endtask

   task automatic press(input bit s, input bit c, input bit f, input bit o,
                        input bit r, input string tag);
      @(negedge clk);
      key_set = s; key_coarse = c; key_fine = f; key_ok = o; key_reset = r;
      @(posedge clk);
      #2;
      key_set = 0; key_coarse = 0; key_fine = 0; key_ok = 0; key_reset = 0;
      model_step(s, c, f, o, r);
      check(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: got running exp finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1 check("R1 reset state");

      // R5: keys ignored outside an edit session
      press(0, 1, 0, 0, 0, "R5 coarse idle");
      press(0, 0, 1, 0, 0, "R5 fine idle");
      press(0, 0, 0, 1, 0, "R5 ok idle");

      // R2 open, then set again ignored
      press(1, 0, 0, 0, 0, "R2 open");
      press(1, 0, 0, 0, 0, "R2 set while editing");

      // R3 walk ladder to saturation, R8 word untouched, R6 ceiling
      for (int i = 0; i < 12; i++) press(0, 1, 0, 0, 0, "R3 R8 coarse walk");
      press(0, 0, 1, 0, 0, "R6 fine at ceiling");
      press(0, 0, 0, 1, 0, "R7 commit top");
      press(0, 0, 0, 0, 0, "R7 strobe one cycle");

      // R4 fine then coarse rejoins ladder
      press(0, 0, 0, 0, 1, "R1 restore key");
      press(1, 0, 0, 0, 0, "R2 open from default");
      for (int i = 0; i < 9; i++) press(0, 0, 1, 0, 0, "R4 fine step");
      press(0, 1, 0, 0, 0, "R3 coarse after fine");
      press(0, 0, 0, 1, 0, "R7 commit");

      // R9 coincident keys
      press(1, 0, 0, 0, 0, "R2 open");
      press(0, 1, 1, 0, 0, "R9 coarse over fine");
      press(1, 1, 1, 1, 0, "R9 ok over others");
      press(1, 1, 0, 0, 0, "R9 set over coarse");
      press(1, 1, 1, 1, 1, "R9 reset over all");

      // random key traffic
      for (int i = 0; i < 3000; i++) begin
         int v = int'($urandom_range(0, 99));
         bit s = (v < 10);
         bit c = (v >= 10 && v < 40) || ($urandom_range(0, 19) == 0);
         bit f = (v >= 40 && v < 75);
         bit o = (v >= 75 && v < 85);
         bit r = (v == 99);
         press(s, c, f, o, r, "R9 random mix");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule